// File: doc/BRIEF.md
# Bus Transaction Watchdog Timer

This block watches transactions on an external memory and peripheral bus and flags any that run too long. When a transaction that uses a wait or transfer-acknowledge handshake starts while the timer is enabled, a 16-bit counter is cleared. The counter then advances once per bus clock until the transaction's completion is seen. If the count climbs above a programmed compare value before completion, the block reports a timeout.

A timeout does four things on one clock edge. It sets a sticky status bit. It records the offending transaction's address and direction. It raises a one-cycle warm-reset request. It returns the compare value to all-ones and forces the timer on. Software reads and writes the block through a small word-addressed register port with three registers: control/status, compare, and captured address. The bus protocol and the reset generator sit outside this block.

Top module: `bus_txn_watchdog`

## Requirements
- R1: After reset, register 0 reads 0 (timer off, no timeout, type read), register 1 reads 0x0000FFFF, register 2 reads 0, and `warm_reset_req` is low.
- R2: Register map, selected by `reg_sel`. Register 0 (control/status) has bit 0 = enable (read/write), bit 1 = timeout (sticky, write 1 to clear) and bit 2 = captured type (read only, 1 = write). Register 1 holds the compare value in bits 15:0. Register 2 holds the captured address and is read only. Bits that are not defined read 0. A select value of 3 reads 0.
- R3: A transaction is timed when `txn_start` is sampled high while enable is 1 and `txn_waitable` is 1. On that edge the counter clears. It then increments once per clock, saturating at 0xFFFF, until `txn_done` is sampled.
- R4: A timeout fires when the counter is strictly greater than the compare value and `txn_done` is not sampled in that same cycle. Take the start as sampled at edge 0 and completion as sampled at edge L+1. The transaction then times out exactly when L >= compare + 2.
- R5: On a timeout, the timeout bit is set, the type bit takes the transaction's `txn_write`, and the captured address takes its `txn_addr`. Both values are the ones sampled with `txn_start`.
- R6: `warm_reset_req` is high for exactly one cycle per timeout. It rises on the same edge that sets the timeout bit.
- R7: On a timeout, the compare value becomes 0xFFFF and enable becomes 1. These override any register write in the same cycle.
- R8: A transaction with `txn_waitable` low, or one started while enable is 0, never causes a timeout. No pulse appears, the status is unchanged, and the compare value is unchanged.
- R9: Writing 0 to the timeout bit leaves it set, and writing 1 clears it. The captured address and type keep their values until the next timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 control/status, 1 compare, 2 captured address) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_sel`) |
| txn_start | input | 1 | Transaction begins this cycle |
| txn_done | input | 1 | Transaction completes this cycle |
| txn_addr | input | 32 | Transaction address, valid with `txn_start` |
| txn_write | input | 1 | Transaction direction, 1 = write, valid with `txn_start` |
| txn_waitable | input | 1 | Target uses a wait/acknowledge handshake |
| warm_reset_req | output | 1 | One-cycle warm-reset request on timeout |

## Verification
The count starts from zero on the edge that samples the start. The timeout condition is therefore true during the cycle after edge compare+1. Status, captured fields, the compare reload and the reset pulse all appear on the following edge, so results land compare+2 edges after the start. Stimulus is driven and outputs are sampled on falling edges. Each transaction is held for a chosen L cycles, and the warm-reset output is watched on every falling edge through the transaction and three cycles after it. Pulse counts and widths are therefore taken across the whole window where a result may fall, not at one guessed instant. Register contents are read back only after that window has closed.

// File: rtl/bus_txn_watchdog.sv
module bus_txn_watchdog #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              txn_start,
  input  logic              txn_done,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic              txn_write,
  input  logic              txn_waitable,
  output logic              warm_reset_req
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_CMP  = 2'd1;
  localparam logic [1:0] SEL_ADDR = 2'd2;

  logic              en, to_flag, ty_wr;
  logic [CNT_W-1:0]  cmp, cnt;
  logic [ADDR_W-1:0] cap_addr, cur_addr;
  logic              cur_wr, active, pulse;

  wire accept = txn_start && en && txn_waitable;
  wire fire   = active && !txn_done && (cnt > cmp);
  wire wr_ctl = reg_we && (reg_sel == SEL_CTRL);
  wire wr_cmp = reg_we && (reg_sel == SEL_CMP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cnt      <= '0;
      cur_addr <= '0;
      cur_wr   <= 1'b0;
    end else if (accept) begin
      active   <= 1'b1;
      cnt      <= '0;
      cur_addr <= txn_addr;
      cur_wr   <= txn_write;
    end else if (fire || txn_done || !en) begin
      active <= 1'b0;
    end else if (active && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      to_flag  <= 1'b0;
      ty_wr    <= 1'b0;
      cmp      <= CNT_MAX;
      cap_addr <= '0;
      pulse    <= 1'b0;
    end else begin
      pulse <= fire;
      if (fire) begin
        to_flag  <= 1'b1;
        ty_wr    <= cur_wr;
        cap_addr <= cur_addr;
        cmp      <= CNT_MAX;
        en       <= 1'b1;
      end else begin
        if (wr_ctl) begin
          en <= reg_wdata[0];
          if (reg_wdata[1]) to_flag <= 1'b0;
        end
        if (wr_cmp) cmp <= reg_wdata[CNT_W-1:0];
      end
    end
  end

  assign warm_reset_req = pulse;

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_CTRL: reg_rdata[2:0] = {ty_wr, to_flag, en};
      SEL_CMP:  reg_rdata[CNT_W-1:0] = cmp;
      SEL_ADDR: reg_rdata[ADDR_W-1:0] = cap_addr;
      default:  reg_rdata = '0;
    endcase
  end

  p_clear_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cnt == '0) && active);

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && en && !txn_start && !txn_done && !fire && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);

  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !accept) |=> cnt == CNT_MAX);

  p_done_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_done && !warm_reset_req) |=> !warm_reset_req);

  p_status_with_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    warm_reset_req |-> to_flag);

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    warm_reset_req |=> !warm_reset_req);

  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    warm_reset_req |-> (cmp == CNT_MAX) && en);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !warm_reset_req) |=> !warm_reset_req);

  p_capture_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !warm_reset_req |-> $stable(cap_addr) && $stable(ty_wr));

endmodule

// File: tb/bus_txn_watchdog_test.sv
module bus_txn_watchdog_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        txn_start = 1'b0, txn_done = 1'b0, txn_write = 1'b0, txn_waitable = 1'b0;
  logic [31:0] txn_addr = '0;
  logic        warm_reset_req;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bus_txn_watchdog uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txn_start(txn_start),
    .txn_done(txn_done), .txn_addr(txn_addr), .txn_write(txn_write),
    .txn_waitable(txn_waitable), .warm_reset_req(warm_reset_req)
  );

  typedef struct packed {
    logic        en;
    logic        wt;
    logic        wr;
    logic [15:0] cmp;
    logic [31:0] addr;
    logic [15:0] len;
    logic        exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b0, 16'd5, 32'h1000_0010, 16'd3,  1'b0},
    '{1'b1, 1'b1, 1'b1, 16'd5, 32'h1000_0020, 16'd20, 1'b1},
    '{1'b1, 1'b1, 1'b0, 16'd5, 32'h1000_0030, 16'd6,  1'b0},
    '{1'b1, 1'b1, 1'b0, 16'd5, 32'h1000_0040, 16'd7,  1'b1},
    '{1'b1, 1'b0, 1'b1, 16'd5, 32'h1000_0050, 16'd20, 1'b0},
    '{1'b1, 1'b1, 1'b1, 16'd0, 32'hABCD_0004, 16'd2,  1'b1},
    '{1'b1, 1'b1, 1'b0, 16'd0, 32'hABCD_0008, 16'd1,  1'b0},
    '{1'b0, 1'b1, 1'b0, 16'd2, 32'h2222_0000, 16'd30, 1'b0},
    '{1'b1, 1'b1, 1'b0, 16'd40, 32'h3333_0000, 16'd42, 1'b1},
    '{1'b1, 1'b1, 1'b1, 16'd40, 32'h4444_0000, 16'd41, 1'b0}
  };

  logic [31:0] last_addr = '0;
  logic        last_wr = 1'b0;
  int          pulses, width, maxw;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic [1:0] sel, output logic [31:0] d);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic watch();
    @(negedge clk);
    if (warm_reset_req) begin
      width++;
      if (width == 1) pulses++;
      if (width > maxw) maxw = width;
    end else width = 0;
  endtask

  task automatic run_txn(input vec_t v);
    wr_reg(2'd1, {16'd0, v.cmp});
    wr_reg(2'd0, {30'd0, 1'b1, v.en});
    pulses = 0; width = 0; maxw = 0;
    txn_start = 1'b1; txn_addr = v.addr; txn_write = v.wr; txn_waitable = v.wt;
    @(negedge clk);
    txn_start = 1'b0; txn_addr = '0; txn_write = 1'b0;
    for (int i = 0; i < int'(v.len); i++) watch();
    txn_done = 1'b1;
    watch();
    txn_done = 1'b0; txn_waitable = 1'b0;
    for (int i = 0; i < 3; i++) watch();
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd_reg(2'd0, d); check("R1 ctrl", d, 32'h0);
    rd_reg(2'd1, d); check("R1 compare", d, 32'h0000_FFFF);
    rd_reg(2'd2, d); check("R1 addr", d, 32'h0);
    check("R1 warm", {31'd0, warm_reset_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 undefined bits and select 3
    wr_reg(2'd0, 32'hFFFF_FFF9);
    rd_reg(2'd0, d); check("R2 ctrl rw bits", d, 32'h1);
    wr_reg(2'd1, 32'h1234_5678);
    rd_reg(2'd1, d); check("R2 compare width", d, 32'h0000_5678);
    rd_reg(2'd3, d); check("R2 sel3", d, 32'h0);

    // R3 R4 R5 R6 R7 R8 table
    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = VECS[k];
      run_txn(v);
      if (v.exp) begin last_addr = v.addr; last_wr = v.wr; end
      check($sformatf("R4 R6 pulses vec%0d", k), pulses, v.exp ? 1 : 0);
      check($sformatf("R6 width vec%0d", k), maxw, v.exp ? 1 : 0);
      rd_reg(2'd0, d);
      check($sformatf("R5 R8 status vec%0d", k), d,
            {29'd0, last_wr, v.exp, v.exp ? 1'b1 : v.en});
      rd_reg(2'd2, d);
      check($sformatf("R5 R9 addr vec%0d", k), d, last_addr);
      rd_reg(2'd1, d);
      check($sformatf("R7 R8 compare vec%0d", k), d, v.exp ? 32'h0000_FFFF : {16'd0, v.cmp});
    end

    // R9 write 0 to timeout bit keeps it, write 1 clears it
    run_txn('{1'b1, 1'b1, 1'b1, 16'd1, 32'h5555_AAAA, 16'd10, 1'b1});
    wr_reg(2'd0, 32'h1);
    rd_reg(2'd0, d); check("R9 write0 keeps", d, 32'h7);
    wr_reg(2'd0, 32'h3);
    rd_reg(2'd0, d); check("R9 write1 clears", d, 32'h5);
    rd_reg(2'd2, d); check("R9 addr held", d, 32'h5555_AAAA);

    // R3 compare 0xFFFF and long transaction never times out
    run_txn('{1'b1, 1'b1, 1'b0, 16'hFFFF, 32'h6666_0000, 16'd200, 1'b0});
    check("R3 R4 no timeout at max compare", pulses, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule